// File: doc/BRIEF.md
# SDRAM Low-Power Entry Manager

This block sits beside an SDRAM controller and puts the memory into a low-power state once the bus has been quiet for long enough. The controller raises a transfer indication while an access is pending or in progress. When that indication drops, the block counts idle cycles and, after a selectable delay, issues a one-cycle request for self-refresh, power-down or deep power-down. It also lowers the clock-enable (CKE) level and, in self-refresh, gates the SDRAM clock.

When a new access arrives while the memory sleeps, the block holds `ready_o` low. It then restores CKE and the clock and releases the access once the memory may take an active command again. Leaving self-refresh waits a programmable exit delay. Deep power-down is left only when software changes the mode. Pin-level command encoding and refresh scheduling belong to the surrounding controller.

Top module: `sdram_lp_mgr`

## Requirements
- R1: After reset, `cke_o`, `clk_en_o` and `ready_o` are high and no low-power request is asserted.
- R2: With `lp_mode_i` = 0 (disabled), no request is ever issued and CKE stays high, however long the bus is idle.
- R3: Idle delay selection `idle_sel_i`: 0 enters low power in the cycle right after the last transfer cycle; 1 enters once 64 full idle cycles have passed (outputs change 65 cycles after `xfer_i` falls); 2 does the same after 128 idle cycles (129 cycles).
- R4: `idle_sel_i` = 3 behaves exactly like 0.
- R5: Any transfer cycle during the idle countdown restarts it from zero.
- R6: With `lp_mode_i` = 1 (self-refresh), entry raises `sr_req_o` for exactly one cycle and drives `cke_o` and `clk_en_o` low.
- R7: With `lp_mode_i` = 2 (power-down), entry raises `pd_req_o` for exactly one cycle and drives `cke_o` low while the clock keeps running.
- R8: An access in power-down brings CKE high and `ready_o` high in the next cycle. An access in self-refresh brings CKE and the clock back in the next cycle and keeps `ready_o` low for `xsr_delay_i`+1 cycles in total.
- R9: After the woken access ends, the block enters the same low-power state again under the current idle delay.
- R10: With `lp_mode_i` = 3 (deep power-down), entry raises `dpd_req_o` for one cycle and drives CKE low. Accesses are ignored (CKE and `ready_o` stay low). Exit happens only when `lp_mode_i` changes to a value other than 3, through the exit delay.
- R11: `ready_o` is high only when CKE is high, and at most one request output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lp_mode_i | input | 2 | Low-power mode: 0 off, 1 self-refresh, 2 power-down, 3 deep power-down |
| idle_sel_i | input | 2 | Idle delay: 0 none, 1 64 cycles, 2 128 cycles, 3 none |
| xsr_delay_i | input | 4 | Self-refresh exit delay in cycles |
| xfer_i | input | 1 | Access pending or in progress |
| cke_o | output | 1 | SDRAM clock-enable level |
| clk_en_o | output | 1 | Gate for the SDRAM clock |
| ready_o | output | 1 | Accesses may proceed |
| sr_req_o | output | 1 | One-cycle self-refresh request |
| pd_req_o | output | 1 | One-cycle power-down request |
| dpd_req_o | output | 1 | One-cycle deep power-down request |

## Verification
The bench aims at the edges of the idle countdown. It checks that CKE is still high one cycle before the 64- and 128-cycle thresholds and low on them. A counter off by one, or one that ignores the restart, would enter a cycle early or late, or fall asleep in the middle of a renewed idle stretch. On self-refresh exit it samples `ready_o` on the last exit cycle and on the first ready cycle, with an exit delay of 3 and of 0. A design that releases early would let an active command violate the exit time. In deep power-down it drives accesses and expects CKE to stay low, which catches a design that wakes up automatically. It also checks that encoding 3 for the idle delay does not leave the block asleep forever or waiting.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

  typedef enum logic [1:0] {
    LP_OFF      = 2'd0,
    LP_SELF_REF = 2'd1,
    LP_PWR_DOWN = 2'd2,
    LP_DEEP_PD  = 2'd3
  } lp_mode_e;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SELF_REF,
    ST_PWR_DOWN,
    ST_DEEP_PD,
    ST_WAKE
  } lp_state_e;

  typedef struct packed {
    logic dpd;
    logic pd;
    logic sr;
  } lp_cmd_t;

endpackage

// File: rtl/lp_idle_timer.sv
module lp_idle_timer #(
  parameter int unsigned SHORT_IDLE = 64,
  parameter int unsigned LONG_IDLE  = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [1:0] sel_i,
  output logic       expired_o
);
  localparam int unsigned CW = $clog2(LONG_IDLE + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  always_comb begin
    case (sel_i)
      2'd1:    limit = CW'(SHORT_IDLE);
      2'd2:    limit = CW'(LONG_IDLE);
      default: limit = '0; // encoding 3 folds onto 0
    endcase
  end

  assign expired_o = (cnt_q >= limit);

  // saturating count of consecutive idle cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (cnt_q != CW'(LONG_IDLE)) cnt_q <= cnt_q + CW'(1);
  end

  p_idle_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));

  p_idle_sat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LONG_IDLE));

endmodule

// File: rtl/lp_exit_timer.sv
module lp_exit_timer #(
  parameter int unsigned DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] delay_i,
  output logic          done_o
);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= delay_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - DW'(1);
  end

  assign done_o = (cnt_q == '0);

  p_exit_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(delay_i)));

  p_exit_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/lp_state_ctrl.sv
module lp_state_ctrl
  import sdram_lp_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic [1:0] mode_i,
  input  logic      xfer_i,
  input  logic      idle_expired_i,
  input  logic      exit_done_i,
  output lp_state_e state_o,
  output lp_cmd_t   cmd_o,
  output logic      exit_load_o,
  output logic      idle_clr_o
);
  lp_state_e state_q, state_d;
  lp_cmd_t   cmd_q, cmd_d;
  lp_mode_e  mode;

  assign mode = lp_mode_e'(mode_i);

  always_comb begin
    state_d     = state_q;
    cmd_d       = '0;
    exit_load_o = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (!xfer_i && idle_expired_i) begin
          case (mode)
            LP_SELF_REF: begin state_d = ST_SELF_REF; cmd_d.sr  = 1'b1; end
            LP_PWR_DOWN: begin state_d = ST_PWR_DOWN; cmd_d.pd  = 1'b1; end
            LP_DEEP_PD:  begin state_d = ST_DEEP_PD;  cmd_d.dpd = 1'b1; end
            default:     state_d = ST_RUN;
          endcase
        end
      end
      ST_SELF_REF: begin
        if (xfer_i) begin
          state_d     = ST_WAKE;
          exit_load_o = 1'b1;
        end
      end
      ST_PWR_DOWN: begin
        if (xfer_i) state_d = ST_RUN;
      end
      ST_DEEP_PD: begin
        // no wake on access; only a mode rewrite leaves
        if (mode != LP_DEEP_PD) begin
          state_d     = ST_WAKE;
          exit_load_o = 1'b1;
        end
      end
      ST_WAKE: begin
        if (exit_done_i) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
    end
  end

  assign idle_clr_o = xfer_i || (state_q != ST_RUN);
  assign state_o    = state_q;
  assign cmd_o      = cmd_q;

  p_no_cmd_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && mode == LP_OFF) |=> (cmd_q == '0));

  p_sr_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q.sr |=> !cmd_q.sr);

  p_pd_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q.pd |=> !cmd_q.pd);

  p_dpd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEEP_PD && mode == LP_DEEP_PD) |=> (state_q == ST_DEEP_PD));

endmodule

// File: rtl/sdram_lp_mgr.sv
module sdram_lp_mgr
  import sdram_lp_pkg::*;
#(
  parameter int unsigned SHORT_IDLE = 64,
  parameter int unsigned LONG_IDLE  = 128,
  parameter int unsigned XSR_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       lp_mode_i,
  input  logic [1:0]       idle_sel_i,
  input  logic [XSR_W-1:0] xsr_delay_i,
  input  logic             xfer_i,
  output logic             cke_o,
  output logic             clk_en_o,
  output logic             ready_o,
  output logic             sr_req_o,
  output logic             pd_req_o,
  output logic             dpd_req_o
);
  lp_state_e state;
  lp_cmd_t   cmd;
  logic      idle_clr, idle_expired;
  logic      exit_load, exit_done;

  lp_idle_timer #(
    .SHORT_IDLE (SHORT_IDLE),
    .LONG_IDLE  (LONG_IDLE)
  ) u_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (idle_clr),
    .sel_i     (idle_sel_i),
    .expired_o (idle_expired)
  );

  lp_exit_timer #(
    .DW (XSR_W)
  ) u_exit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (exit_load),
    .delay_i (xsr_delay_i),
    .done_o  (exit_done)
  );

  lp_state_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mode_i         (lp_mode_i),
    .xfer_i         (xfer_i),
    .idle_expired_i (idle_expired),
    .exit_done_i    (exit_done),
    .state_o        (state),
    .cmd_o          (cmd),
    .exit_load_o    (exit_load),
    .idle_clr_o     (idle_clr)
  );

  assign cke_o     = (state == ST_RUN) || (state == ST_WAKE);
  assign clk_en_o  = (state != ST_SELF_REF);
  assign ready_o   = (state == ST_RUN);
  assign sr_req_o  = cmd.sr;
  assign pd_req_o  = cmd.pd;
  assign dpd_req_o = cmd.dpd;

  p_ready_cke_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> cke_o);

  p_req_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sr_req_o, pd_req_o, dpd_req_o}));

  p_sr_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_req_o |-> (!clk_en_o && !cke_o));

  p_pd_clk_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_req_o |-> (clk_en_o && !cke_o));

  p_pd_wake_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && clk_en_o && xfer_i && lp_mode_i != 2'd3 && !dpd_req_o && state == ST_PWR_DOWN)
      |=> (cke_o && ready_o));

endmodule

// File: tb/sdram_lp_mgr_bench.sv
module sdram_lp_mgr_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] lp_mode;
  logic [1:0] idle_sel;
  logic [3:0] xsr;
  logic       xfer;
  logic       cke, clk_en, ready, sr_req, pd_req, dpd_req;

  typedef struct {
    int         cyc;
    logic       cke;
    logic       clk_en;
    logic       ready;
    logic [2:0] cmd; // {dpd, pd, sr}
    string      tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_lp_mgr u_sdram_lp_mgr (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .lp_mode_i   (lp_mode),
    .idle_sel_i  (idle_sel),
    .xsr_delay_i (xsr),
    .xfer_i      (xfer),
    .cke_o       (cke),
    .clk_en_o    (clk_en),
    .ready_o     (ready),
    .sr_req_o    (sr_req),
    .pd_req_o    (pd_req),
    .dpd_req_o   (dpd_req)
  );

  // monitor: compare expected items against outputs away from the edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      logic [5:0] act, want;
      e = q.pop_front();
      act  = {cke, clk_en, ready, dpd_req, pd_req, sr_req};
      want = {e.cke, e.clk_en, e.ready, e.cmd};
      n_chk++;
      if (e.cyc != cyc || act !== want) begin
        n_fail++;
        $display("FAIL %s @cyc %0d: {cke,clk_en,ready,dpd,pd,sr} actual %b expected %b (due cyc %0d)",
                 e.tag, cyc, act, want, e.cyc);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic expect_at(int ofs, logic k, logic c, logic r, logic [2:0] cmd, string tag);
    q.push_back('{cyc + ofs, k, c, r, cmd, tag});
  endtask

  task automatic expect_run(int ofs, string tag);
    expect_at(ofs, 1'b1, 1'b1, 1'b1, 3'b000, tag);
  endtask

  task automatic settle(logic [1:0] m, logic [1:0] s);
    lp_mode  = m;
    idle_sel = s;
    xfer     = 1'b1;
    idle(20);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual run still busy, expected finished");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; lp_mode = 2'd0; idle_sel = 2'd0; xsr = 4'd0; xfer = 1'b0;
    idle(3);
    rst_n = 1'b1;
    expect_run(1, "R1 reset state");
    expect_run(2, "R1 reset state");
    idle(3);

    // disabled: long idle never sleeps
    expect_run(1,   "R2 disabled");
    expect_run(65,  "R2 disabled");
    expect_run(129, "R2 disabled");
    expect_run(140, "R2 disabled");
    idle(150);

    // power-down, no idle delay
    settle(2'd2, 2'd0);
    xfer = 1'b0;
    expect_at(1, 1'b0, 1'b1, 1'b0, 3'b010, "R3 R7 pd entry");
    expect_at(2, 1'b0, 1'b1, 1'b0, 3'b000, "R7 pd pulse ends");
    idle(5);
    xfer = 1'b1;
    expect_run(1, "R8 pd exit");
    idle(2);
    xfer = 1'b0;
    expect_at(1, 1'b0, 1'b1, 1'b0, 3'b010, "R9 pd re-entry");
    idle(3);

    // delay encoding 3 behaves like 0
    settle(2'd2, 2'd3);
    xfer = 1'b0;
    expect_at(1, 1'b0, 1'b1, 1'b0, 3'b010, "R4 sel 3 immediate");
    idle(3);

    // 64-cycle delay
    settle(2'd2, 2'd1);
    xfer = 1'b0;
    expect_run(64, "R3 64 not yet");
    expect_at(65, 1'b0, 1'b1, 1'b0, 3'b010, "R3 64 entry");
    idle(70);

    // restart of countdown
    settle(2'd2, 2'd1);
    xfer = 1'b0;
    idle(30);
    xfer = 1'b1;
    step();
    xfer = 1'b0;
    expect_run(34, "R5 no entry from old count");
    expect_run(64, "R5 restarted not yet");
    expect_at(65, 1'b0, 1'b1, 1'b0, 3'b010, "R5 restarted entry");
    idle(70);

    // self-refresh, 128-cycle delay, exit delay 3
    xsr = 4'd3;
    settle(2'd1, 2'd2);
    xfer = 1'b0;
    expect_run(128, "R3 128 not yet");
    expect_at(129, 1'b0, 1'b0, 1'b0, 3'b001, "R3 R6 sr entry");
    expect_at(130, 1'b0, 1'b0, 1'b0, 3'b000, "R6 sr pulse ends");
    idle(135);
    xfer = 1'b1;
    expect_at(1, 1'b1, 1'b1, 1'b0, 3'b000, "R8 R11 sr wake clock back");
    expect_at(4, 1'b1, 1'b1, 1'b0, 3'b000, "R8 last exit cycle");
    expect_run(5, "R8 ready after exit delay");
    idle(6);
    idle_sel = 2'd0;
    xfer = 1'b0;
    expect_at(1, 1'b0, 1'b0, 1'b0, 3'b001, "R9 sr re-entry");
    idle(3);

    // deep power-down, exit delay 0
    xsr = 4'd0;
    settle(2'd3, 2'd0);
    xfer = 1'b0;
    expect_at(1, 1'b0, 1'b1, 1'b0, 3'b100, "R10 dpd entry");
    expect_at(2, 1'b0, 1'b1, 1'b0, 3'b000, "R10 dpd pulse ends");
    idle(3);
    xfer = 1'b1;
    expect_at(1,  1'b0, 1'b1, 1'b0, 3'b000, "R10 access ignored");
    expect_at(5,  1'b0, 1'b1, 1'b0, 3'b000, "R10 access ignored");
    expect_at(10, 1'b0, 1'b1, 1'b0, 3'b000, "R10 access ignored");
    idle(10);
    lp_mode = 2'd0;
    expect_at(1, 1'b1, 1'b1, 1'b0, 3'b000, "R10 R11 dpd exit wait");
    expect_run(2, "R10 dpd exit done");
    idle(5);

    if (q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL queue: actual %0d items left, expected 0", q.size());
    end
    report();
    $finish;
  end

endmodule